// File: doc/BRIEF.md
# Inline ECC Command Generator

This block sits between a simple one-word request port and a 16-bit memory command port. The check codes for the data live in the same channel as the data, in a reserved address partition. No extra lanes carry them, so the block issues its own overhead commands to that partition. Each 16-bit data word gets an 8-bit single-error-correct, double-error-detect check byte. The check bytes of four consecutive aligned words form a group, and a group fills two 16-bit words of check storage.

On the write side, the data word goes to memory at once. Its check byte is collected in a single open group buffer, which tracks each word with a valid mask. The buffer is written back with overhead writes in three cases: all four words are present, a write targets another group, or the flush input is raised. If the buffer is only partly filled, the missing check bytes are first read back from memory and merged in. On the read side, the most recently fetched group of check bytes is held in a one-entry cache. A read that hits it needs only the data read. The read response carries the corrected word and two error flags, in request order. Each corrected error also produces a one-cycle pulse with the address, for logging.

Top module: `inline_ecc_cmd_gen`

## Requirements
- R1: The check storage of data address `a` is the two words at `ECC_BASE + 2*(a>>2)` (check bytes of group words 0 and 1, word 0 in bits 7:0) and `ECC_BASE + 2*(a>>2) + 1` (words 2 and 3, word 2 in bits 7:0).
- R2: A check byte holds five Hamming bits in bits 4:0, an overall parity bit in bit 5 equal to the XOR of the 16 data bits and bits 4:0, and zero in bits 7:6.
- R3: Each accepted write produces exactly one memory write to the request address carrying the request data unchanged.
- R4: Four writes that fill one aligned group produce exactly two overhead writes and no overhead read.
- R5: A write to another group flushes a partly filled open group. Each partly covered check word is read, merged and written back. A check word with no new byte gets no command. Check bytes of words not rewritten are preserved.
- R6: Raising `flush_i` with an open group writes it back. With no open group, and after reset, no memory command is issued.
- R7: A read whose group is not cached issues both check-word reads and then the data read. A read whose group is cached issues only the data read.
- R8: A read of an undamaged word returns the stored data with both flags low, as a one-cycle `rsp_valid_o` pulse.
- R9: A single flipped data bit is corrected. `rsp_sbe_o` is high, and `err_pulse_o` pulses with `err_addr_o` equal to the read address.
- R10: Two flipped data bits raise `rsp_dbe_o` with `rsp_sbe_o` low and no error pulse.
- R11: A write to the cached group updates the cached check byte, so later reads of that group stay hits and decode clean.
- R12: While `mem_valid_o` is high and `mem_ready_i` is low, the command address, direction and data hold steady.
- R13: A read to the group held open in the write buffer first flushes that group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Data word address |
| req_wdata_i | input | 16 | Write data |
| flush_i | input | 1 | Write back the open check-byte group |
| mem_valid_o | output | 1 | Memory command valid |
| mem_ready_i | input | 1 | Memory command accepted |
| mem_we_o | output | 1 | Memory command is a write |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rvalid_i | input | 1 | Read data returned, in command order |
| mem_rdata_i | input | 16 | Read data |
| rsp_valid_o | output | 1 | Read response pulse |
| rsp_data_o | output | 16 | Corrected read data |
| rsp_sbe_o | output | 1 | Single error corrected |
| rsp_dbe_o | output | 1 | Uncorrectable double error |
| err_pulse_o | output | 1 | Corrected-error log pulse |
| err_addr_o | output | ADDR_W | Address of the corrected error |

## Verification
The bench builds the block with `ADDR_W = 8` and `ECC_BASE = 128`. Data and check partitions then both fit in a 256-word memory model, and the bench can inspect every check word the block writes. The small space also lets scattered addresses land in the same groups, so group changes, cache hits and cache misses all occur. The model stalls `mem_ready_i` on a pseudo-random pattern. The bench flips bits directly in the model's data words to inject errors.

// File: rtl/inline_ecc_pkg.sv
package inline_ecc_pkg;
  localparam int DATA_W    = 16;
  localparam int HAM_W     = 5;
  localparam int CHK_W     = 8;
  localparam int GRP_WORDS = 4;
  localparam int IDX_W     = $clog2(GRP_WORDS);
  localparam int BPW       = DATA_W / CHK_W;      // check bytes per storage word
  localparam int ECC_WORDS = GRP_WORDS / BPW;     // storage words per group
  localparam int HALF_W    = (ECC_WORDS > 1) ? $clog2(ECC_WORDS) : 1;
  localparam int MAX_POS   = DATA_W + HAM_W;

  // Hamming position of data bit idx (non-power-of-two slots, 1-based)
  function automatic int code_pos(input int idx);
    int pos;
    int n;
    pos = 0;
    n = -1;
    for (int p = 1; p <= MAX_POS; p++) begin
      if ((p & (p - 1)) != 0) begin
        n++;
        if (n == idx) pos = p;
      end
    end
    return pos;
  endfunction

  typedef enum logic [3:0] {
    ST_IDLE, ST_GO, ST_FCHK, ST_FRD, ST_FWAIT, ST_FWR,
    ST_CRD, ST_CWAIT, ST_DWR, ST_DRD, ST_DWAIT
  } iecc_state_e;
endpackage

// File: rtl/iecc_secded_enc.sv
module iecc_secded_enc
  import inline_ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  logic [HAM_W-1:0] ham;

  always_comb begin
    ham = '0;
    for (int i = 0; i < DATA_W; i++)
      for (int j = 0; j < HAM_W; j++)
        if (((code_pos(i) >> j) & 1) != 0) ham[j] = ham[j] ^ data_i[i];
    chk_o = '0;
    chk_o[HAM_W-1:0] = ham;
    chk_o[HAM_W]     = ^{data_i, ham};
  end
endmodule

// File: rtl/iecc_secded_dec.sv
module iecc_secded_dec
  import inline_ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sbe_o,
  output logic              dbe_o
);
  logic [CHK_W-1:0] chk_calc;
  logic [HAM_W-1:0] syn;
  logic             perr;
  logic             unused_pad;

  iecc_secded_enc u_enc (.data_i(data_i), .chk_o(chk_calc));

  assign syn  = chk_i[HAM_W-1:0] ^ chk_calc[HAM_W-1:0];
  assign perr = chk_i[HAM_W] ^ chk_calc[HAM_W] ^ (^syn);
  assign unused_pad = ^{chk_i[CHK_W-1:HAM_W+1], chk_calc[CHK_W-1:HAM_W+1]};

  always_comb begin
    data_o = data_i;
    sbe_o  = 1'b0;
    dbe_o  = 1'b0;
    if (perr) begin
      if (int'(syn) > MAX_POS) dbe_o = 1'b1;
      else begin
        sbe_o = 1'b1;
        for (int i = 0; i < DATA_W; i++)
          if (code_pos(i) == int'(syn)) data_o[i] = ~data_i[i];
      end
    end else if (syn != '0) begin
      dbe_o = 1'b1;
    end
  end
endmodule

// File: rtl/inline_ecc_cmd_gen.sv
module inline_ecc_cmd_gen
  import inline_ecc_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int ECC_BASE = 'hC000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              flush_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              rsp_sbe_o,
  output logic              rsp_dbe_o,
  output logic              err_pulse_o,
  output logic [ADDR_W-1:0] err_addr_o
);
  localparam int GRP_W = ADDR_W - IDX_W;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(ECC_BASE);
  localparam logic [HALF_W-1:0] LAST_HALF = HALF_W'(ECC_WORDS - 1);

  iecc_state_e state_q;
  logic              p_we_q;
  logic [ADDR_W-1:0] p_addr_q;
  logic [DATA_W-1:0] p_wdata_q;
  logic              after_flush_q;
  logic [HALF_W-1:0] half_q;

  logic                             buf_open_q;
  logic [GRP_W-1:0]                 buf_tag_q;
  logic [GRP_WORDS-1:0]             buf_mask_q;
  logic [GRP_WORDS-1:0][CHK_W-1:0]  buf_chk_q;
  logic                             cache_vld_q;
  logic [GRP_W-1:0]                 cache_tag_q;
  logic [GRP_WORDS-1:0][CHK_W-1:0]  cache_chk_q;

  logic              rsp_valid_q, rsp_sbe_q, rsp_dbe_q, err_pulse_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [ADDR_W-1:0] err_addr_q;

  logic [GRP_W-1:0]  p_grp, in_grp;
  logic [IDX_W-1:0]  p_idx;
  logic              need_flush, last_half, cache_hit;
  logic [BPW-1:0]    half_mask;
  logic [DATA_W-1:0] buf_word;
  logic [CHK_W-1:0]  wr_chk;
  logic [DATA_W-1:0] dec_data;
  logic              dec_sbe, dec_dbe;

  assign p_grp      = p_addr_q[ADDR_W-1:IDX_W];
  assign p_idx      = p_addr_q[IDX_W-1:0];
  assign in_grp     = req_addr_i[ADDR_W-1:IDX_W];
  assign last_half  = (half_q == LAST_HALF);
  assign half_mask  = buf_mask_q[int'(half_q)*BPW +: BPW];
  assign cache_hit  = cache_vld_q && (cache_tag_q == p_grp);
  assign need_flush = buf_open_q &&
                      (req_we_i ? (buf_tag_q != in_grp) : (buf_tag_q == in_grp));

  always_comb begin
    for (int b = 0; b < BPW; b++)
      buf_word[b*CHK_W +: CHK_W] = buf_chk_q[int'(half_q)*BPW + b];
  end

  iecc_secded_enc u_enc (.data_i(p_wdata_q), .chk_o(wr_chk));
  iecc_secded_dec u_dec (
    .data_i(mem_rdata_i), .chk_i(cache_chk_q[p_idx]),
    .data_o(dec_data), .sbe_o(dec_sbe), .dbe_o(dec_dbe)
  );

  // memory command decode
  always_comb begin
    mem_valid_o = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_FRD: begin
        mem_valid_o = 1'b1;
        mem_addr_o  = BASE_A + ADDR_W'({buf_tag_q, half_q});
      end
      ST_FWR: begin
        mem_valid_o = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = BASE_A + ADDR_W'({buf_tag_q, half_q});
        mem_wdata_o = buf_word;
      end
      ST_CRD: begin
        mem_valid_o = 1'b1;
        mem_addr_o  = BASE_A + ADDR_W'({p_grp, half_q});
      end
      ST_DWR: begin
        mem_valid_o = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = p_addr_q;
        mem_wdata_o = p_wdata_q;
      end
      ST_DRD: begin
        mem_valid_o = 1'b1;
        mem_addr_o  = p_addr_q;
      end
      default: ;
    endcase
  end

  assign req_ready_o = (state_q == ST_IDLE) && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      p_we_q        <= 1'b0;
      p_addr_q      <= '0;
      p_wdata_q     <= '0;
      after_flush_q <= 1'b0;
      half_q        <= '0;
      buf_open_q    <= 1'b0;
      buf_tag_q     <= '0;
      buf_mask_q    <= '0;
      buf_chk_q     <= '0;
      cache_vld_q   <= 1'b0;
      cache_tag_q   <= '0;
      cache_chk_q   <= '0;
      rsp_valid_q   <= 1'b0;
      rsp_data_q    <= '0;
      rsp_sbe_q     <= 1'b0;
      rsp_dbe_q     <= 1'b0;
      err_pulse_q   <= 1'b0;
      err_addr_q    <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      err_pulse_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (flush_i) begin
            if (buf_open_q) begin
              after_flush_q <= 1'b0;
              half_q        <= '0;
              state_q       <= ST_FCHK;
            end
          end else if (req_valid_i) begin
            p_we_q    <= req_we_i;
            p_addr_q  <= req_addr_i;
            p_wdata_q <= req_wdata_i;
            if (need_flush) begin
              after_flush_q <= 1'b1;
              half_q        <= '0;
              state_q       <= ST_FCHK;
            end else begin
              state_q <= ST_GO;
            end
          end
        end
        ST_GO: begin
          if (p_we_q) state_q <= ST_DWR;
          else if (cache_hit) state_q <= ST_DRD;
          else begin
            half_q      <= '0;
            cache_vld_q <= 1'b0;
            state_q     <= ST_CRD;
          end
        end
        ST_FCHK: begin
          if (half_mask == '0) begin
            if (last_half) begin
              buf_open_q <= 1'b0;
              buf_mask_q <= '0;
              state_q    <= after_flush_q ? ST_GO : ST_IDLE;
            end else begin
              half_q <= half_q + HALF_W'(1);
            end
          end else if (&half_mask) state_q <= ST_FWR;
          else state_q <= ST_FRD;
        end
        ST_FRD: if (mem_ready_i) state_q <= ST_FWAIT;
        ST_FWAIT: begin
          if (mem_rvalid_i) begin
            // keep fresh bytes, take the stored ones for the rest
            for (int b = 0; b < BPW; b++)
              if (!buf_mask_q[int'(half_q)*BPW + b])
                buf_chk_q[int'(half_q)*BPW + b] <= mem_rdata_i[b*CHK_W +: CHK_W];
            state_q <= ST_FWR;
          end
        end
        ST_FWR: begin
          if (mem_ready_i) begin
            if (last_half) begin
              buf_open_q <= 1'b0;
              buf_mask_q <= '0;
              state_q    <= after_flush_q ? ST_GO : ST_IDLE;
            end else begin
              half_q  <= half_q + HALF_W'(1);
              state_q <= ST_FCHK;
            end
          end
        end
        ST_CRD: if (mem_ready_i) state_q <= ST_CWAIT;
        ST_CWAIT: begin
          if (mem_rvalid_i) begin
            for (int b = 0; b < BPW; b++)
              cache_chk_q[int'(half_q)*BPW + b] <= mem_rdata_i[b*CHK_W +: CHK_W];
            if (last_half) begin
              cache_vld_q <= 1'b1;
              cache_tag_q <= p_grp;
              state_q     <= ST_DRD;
            end else begin
              half_q  <= half_q + HALF_W'(1);
              state_q <= ST_CRD;
            end
          end
        end
        ST_DWR: begin
          if (mem_ready_i) begin
            buf_chk_q[p_idx]  <= wr_chk;
            buf_mask_q[p_idx] <= 1'b1;
            buf_tag_q         <= p_grp;
            buf_open_q        <= 1'b1;
            if (cache_hit) cache_chk_q[p_idx] <= wr_chk;
            if (&(buf_mask_q | (GRP_WORDS'(1) << p_idx))) begin
              after_flush_q <= 1'b0;
              half_q        <= '0;
              state_q       <= ST_FCHK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_DRD: if (mem_ready_i) state_q <= ST_DWAIT;
        ST_DWAIT: begin
          if (mem_rvalid_i) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= dec_data;
            rsp_sbe_q   <= dec_sbe;
            rsp_dbe_q   <= dec_dbe;
            err_pulse_q <= dec_sbe;
            err_addr_q  <= p_addr_q;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign rsp_sbe_o   = rsp_sbe_q;
  assign rsp_dbe_o   = rsp_dbe_q;
  assign err_pulse_o = err_pulse_q;
  assign err_addr_o  = err_addr_q;
endmodule

// File: rtl/inline_ecc_cmd_gen_chk.sv
module inline_ecc_cmd_gen_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [15:0]       mem_wdata_o,
  input logic              mem_rvalid_i,
  input logic              rsp_valid_o,
  input logic              rsp_sbe_o,
  input logic              rsp_dbe_o,
  input logic              err_pulse_o
);
  assert_cmd_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o)
                                    && $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_err_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |-> rsp_valid_o && rsp_sbe_o);

  assert_flag_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !(rsp_sbe_o && rsp_dbe_o));

  assert_rsp_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_rsp_after_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(mem_rvalid_i));

  // R3: one request in flight, no acceptance while a command is pending
  assert_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> !req_ready_o);
endmodule

bind inline_ecc_cmd_gen inline_ecc_cmd_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o),
  .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rvalid_i(mem_rvalid_i),
  .rsp_valid_o(rsp_valid_o), .rsp_sbe_o(rsp_sbe_o), .rsp_dbe_o(rsp_dbe_o),
  .err_pulse_o(err_pulse_o)
);

// File: tb/inline_ecc_cmd_gen_bench.sv
module inline_ecc_cmd_gen_bench;
  localparam int AW = 8;
  localparam int EB = 128;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n;

  logic req_valid, req_ready, req_we, flush;
  logic [AW-1:0] req_addr;
  logic [15:0] req_wdata;
  logic mem_valid, mem_ready, mem_we, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic rsp_valid, rsp_sbe, rsp_dbe, err_pulse;
  logic [15:0] rsp_data;
  logic [AW-1:0] err_addr;

  inline_ecc_cmd_gen #(.ADDR_W(AW), .ECC_BASE(EB)) u_inline_ecc_cmd_gen (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .flush_i(flush),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_sbe_o(rsp_sbe),
    .rsp_dbe_o(rsp_dbe), .err_pulse_o(err_pulse), .err_addr_o(err_addr)
  );

  // ---------------- memory model ----------------
  logic [15:0] mem [256];
  int n_ecc_wr, n_ecc_rd, n_dat_wr, n_dat_rd, hold_seen, hold_viol;
  logic [AW-1:0] ecc_wa0, ecc_wa1;
  logic [3:0] lfsr;
  logic rd_v1;
  logic [15:0] rd_d1;
  logic pend, pend_we;
  logic [AW-1:0] pend_addr;
  logic [15:0] pend_wd;
  logic inj_go;
  logic [AW-1:0] inj_addr;
  logic [15:0] inj_mask;

  assign mem_ready = lfsr[0] | lfsr[1];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
      lfsr <= 4'b1001;
      rd_v1 <= 1'b0; rd_d1 <= '0; mem_rvalid <= 1'b0; mem_rdata <= '0;
      n_ecc_wr <= 0; n_ecc_rd <= 0; n_dat_wr <= 0; n_dat_rd <= 0;
      hold_seen <= 0; hold_viol <= 0; pend <= 1'b0;
      ecc_wa0 <= '0; ecc_wa1 <= '0;
    end else begin
      lfsr <= {lfsr[2:0], lfsr[3] ^ lfsr[2]};
      mem_rvalid <= rd_v1;
      mem_rdata  <= rd_d1;
      rd_v1 <= 1'b0;
      if (pend) begin
        hold_seen <= hold_seen + 1;
        if (!mem_valid || mem_addr != pend_addr || mem_we != pend_we || mem_wdata != pend_wd)
          hold_viol <= hold_viol + 1;
      end
      pend <= mem_valid && !mem_ready;
      pend_addr <= mem_addr; pend_we <= mem_we; pend_wd <= mem_wdata;
      if (inj_go) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          mem[mem_addr] <= mem_wdata;
          if (int'(mem_addr) >= EB) begin
            n_ecc_wr <= n_ecc_wr + 1; ecc_wa0 <= mem_addr; ecc_wa1 <= ecc_wa0;
          end else n_dat_wr <= n_dat_wr + 1;
        end else begin
          rd_v1 <= 1'b1;
          rd_d1 <= mem[mem_addr];
          if (int'(mem_addr) >= EB) n_ecc_rd <= n_ecc_rd + 1;
          else n_dat_rd <= n_dat_rd + 1;
        end
      end
    end
  end

  // ---------------- helpers ----------------
  int n_checks = 0;
  int n_errors = 0;
  logic [15:0] r_data;
  logic r_sbe, r_dbe, r_pulse, r_got;
  logic [AW-1:0] r_eaddr;
  int s_ewr, s_erd, s_dwr, s_drd;
  logic [15:0] shadow [128];
  logic shadow_v [128];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic snap();
    s_ewr = n_ecc_wr; s_erd = n_ecc_rd; s_dwr = n_dat_wr; s_drd = n_dat_rd;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d);
    wait_idle();
    req_we = 1'b1; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
  endtask

  task automatic do_flush();
    wait_idle();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    wait_idle();
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    wait_idle();
    req_we = 1'b0; req_addr = a; req_valid = 1'b1;
    r_got = 1'b0; r_pulse = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 200 && !r_got; i++) begin
      if (rsp_valid) begin
        r_got = 1'b1; r_data = rsp_data; r_sbe = rsp_sbe; r_dbe = rsp_dbe;
        r_pulse = err_pulse; r_eaddr = err_addr;
      end else @(negedge clk);
    end
    chk("R8 response arrives", 32'(r_got), 1);
    @(negedge clk);
    chk("R8 response is one cycle", 32'(rsp_valid), 0);
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [15:0] m);
    @(negedge clk);
    inj_addr = a; inj_mask = m; inj_go = 1'b1;
    @(negedge clk);
    inj_go = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk("R6 reset ready", 32'(req_ready), 1);
    chk("R6 reset no command", 32'(mem_valid), 0);
    chk("R6 reset no response", 32'(rsp_valid), 0);
  endtask

  task automatic t_seq_burst();
    logic [15:0] vals [4];
    logic [7:0] cb;
    vals[0] = 16'h1234; vals[1] = 16'hFFFF; vals[2] = 16'h0001; vals[3] = 16'h8000;
    snap();
    for (int i = 0; i < 4; i++) do_write(AW'(4 + i), vals[i]);
    chk("R3 data writes", 32'(n_dat_wr - s_dwr), 4);
    chk("R4 overhead writes", 32'(n_ecc_wr - s_ewr), 2);
    chk("R4 no overhead reads", 32'(n_ecc_rd - s_erd), 0);
    for (int i = 0; i < 4; i++) chk("R3 data stored", 32'(mem[4 + i]), 32'(vals[i]));
    chk("R1 first check word addr", 32'(ecc_wa1), 130);
    chk("R1 second check word addr", 32'(ecc_wa0), 131);
    for (int i = 0; i < 4; i++) begin
      cb = mem[130 + i / 2][(i % 2) * 8 +: 8];
      chk("R2 pad bits zero", 32'(cb[7:6]), 0);
      chk("R2 overall parity", 32'(^{vals[i], cb[4:0]}), 32'(cb[5]));
    end
    snap();
    for (int i = 0; i < 4; i++) begin
      do_read(AW'(4 + i));
      chk("R8 clean data", 32'(r_data), 32'(vals[i]));
      chk("R8 clean flags", 32'({r_sbe, r_dbe}), 0);
    end
    chk("R7 one group fetch", 32'(n_ecc_rd - s_erd), 2);
    chk("R7 data reads", 32'(n_dat_rd - s_drd), 4);
  endtask

  task automatic t_partial();
    logic [15:0] vals [4];
    vals[0] = 16'h0BAD; vals[1] = 16'hCAFE; vals[2] = 16'h5A5A; vals[3] = 16'h7E57;
    for (int i = 0; i < 4; i++) do_write(AW'(8 + i), vals[i]);
    do_write(9, 16'h1111);
    vals[1] = 16'h1111;
    snap();
    do_write(20, 16'h2020);
    chk("R5 merge read count", 32'(n_ecc_rd - s_erd), 1);
    chk("R5 merge write count", 32'(n_ecc_wr - s_ewr), 1);
    chk("R5 merged word addr", 32'(ecc_wa0), 132);
    for (int i = 0; i < 4; i++) begin
      do_read(AW'(8 + i));
      chk("R5 preserved data", 32'(r_data), 32'(vals[i]));
      chk("R5 preserved flags", 32'({r_sbe, r_dbe}), 0);
    end
  endtask

  task automatic t_flush();
    snap();
    do_flush();
    chk("R6 flush read", 32'(n_ecc_rd - s_erd), 1);
    chk("R6 flush write", 32'(n_ecc_wr - s_ewr), 1);
    chk("R6 flush addr", 32'(ecc_wa0), 138);
    snap();
    do_flush();
    repeat (5) @(negedge clk);
    chk("R6 empty flush no command",
        32'((n_ecc_rd - s_erd) + (n_ecc_wr - s_ewr) + (n_dat_rd - s_drd) + (n_dat_wr - s_dwr)), 0);
  endtask

  task automatic t_hit();
    snap();
    do_read(20);
    chk("R7 miss fetches group", 32'(n_ecc_rd - s_erd), 2);
    chk("R8 miss data", 32'(r_data), 16'h2020);
    snap();
    do_read(21);
    chk("R7 hit no fetch", 32'(n_ecc_rd - s_erd), 0);
    chk("R7 hit data read", 32'(n_dat_rd - s_drd), 1);
    chk("R8 unwritten word clean", 32'({r_data, r_sbe, r_dbe}), 0);
  endtask

  task automatic t_update();
    do_write(22, 16'h4242);
    snap();
    do_read(22);
    chk("R13 flush read before read", 32'(n_ecc_rd - s_erd), 1);
    chk("R13 flush write before read", 32'(n_ecc_wr - s_ewr), 1);
    chk("R11 updated data", 32'(r_data), 16'h4242);
    chk("R11 updated flags", 32'({r_sbe, r_dbe}), 0);
    snap();
    do_read(20);
    chk("R11 still a hit", 32'(n_ecc_rd - s_erd), 0);
    chk("R11 neighbour clean", 32'({r_data, r_sbe, r_dbe}), {16'h2020, 2'b00});
  endtask

  task automatic t_single();
    do_write(40, 16'hA5C3);
    do_flush();
    for (int b = 0; b < 16; b++) begin
      inject(40, 16'(1) << b);
      do_read(40);
      chk("R9 corrected data", 32'(r_data), 16'hA5C3);
      chk("R9 flags", 32'({r_sbe, r_dbe}), 2'b10);
      chk("R9 log pulse", 32'(r_pulse), 1);
      chk("R9 log addr", 32'(r_eaddr), 40);
      inject(40, 16'(1) << b);
    end
  endtask

  task automatic t_double();
    inject(40, 16'h0201);
    do_read(40);
    chk("R10 flags", 32'({r_sbe, r_dbe}), 2'b01);
    chk("R10 no log pulse", 32'(r_pulse), 0);
    inject(40, 16'h0201);
    do_read(40);
    chk("R10 restored clean", 32'({r_data, r_sbe, r_dbe}), {16'hA5C3, 2'b00});
  endtask

  task automatic t_scatter();
    for (int i = 0; i < 128; i++) shadow_v[i] = 1'b0;
    for (int k = 0; k < 24; k++) begin
      int a;
      logic [15:0] d;
      a = (k * 37 + 11) & 127;
      d = 16'(k * 16'h1357) ^ 16'hBEEF;
      do_write(AW'(a), d);
      shadow[a] = d; shadow_v[a] = 1'b1;
    end
    do_flush();
    for (int a = 0; a < 128; a++) begin
      if (shadow_v[a]) begin
        do_read(AW'(a));
        chk("R8 scatter data", 32'(r_data), 32'(shadow[a]));
        chk("R8 scatter flags", 32'({r_sbe, r_dbe}), 0);
      end
    end
  endtask

  task automatic t_stall();
    chk("R12 stalls observed", 32'(hold_seen > 0), 1);
    chk("R12 command held", 32'(hold_viol), 0);
  endtask

  // ---------------- run ----------------
  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    flush = 1'b0; inj_go = 1'b0; inj_addr = '0; inj_mask = '0;
    repeat (4) @(negedge clk);
    chk("R6 in reset no command", 32'(mem_valid), 0);
    rst_n = 1'b1;
    t_reset();
    t_seq_burst();
    t_partial();
    t_flush();
    t_hit();
    t_update();
    t_single();
    t_double();
    t_scatter();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule